// File: doc/BRIEF.md
# Set-Associative Tag Lookup and Victim Selection

This unit holds the tag store of a set-associative cache and answers, in the same cycle, whether a word address is held. The number of ways is a parameter. Each way has its own bank of per-set entries, and each entry carries a tag and a valid flag. The lookup address is split into a word offset, a set index and a tag. Every way compares its entry for the indexed set against the tag in parallel, and the result is a per-way hit vector and a single hit flag.

On every cycle the unit also proposes a victim way for the looked-up set. A way that holds nothing is always preferred. Only when every way is occupied does the replacement state pick one. A separate allocate port writes a tag into a named way of a set and marks it valid. The caller normally passes the victim it was given on a miss. With one way the unit is a direct-mapped tag store. With as many ways as frames it is fully associative with a single set.

Data storage and the path to main memory are handled elsewhere.

Top module: `lkp_set_assoc_tags`

## Requirements
- R1: A word address splits into three fields, from least significant upward: a word offset of log2(BLOCK_WORDS) bits, which is ignored; a set index of log2(FRAMES/WAYS) bits; and the remaining bits as the tag. With the default geometry these are addr[2:0], addr[4:3] and addr[6:5].
- R2: Reset clears every valid flag, so every lookup misses (hit_way all zero, hit low) until an allocation is made.
- R3: Bit w of hit_way is 1 exactly when way w's entry for the looked-up set is valid and holds the looked-up tag. The hit output is 1 when any bit of hit_way is 1. Lookup outputs are combinational from the stored state.
- R4: hit_way is one-hot or all zero, provided the caller allocates a tag only into a set where it misses, or into the way that already holds it.
- R5: While alloc_en is high, the rising edge writes the tag of alloc_addr into way alloc_way of its set and sets that entry valid. A lookup of that block in the next cycle hits on that way. A lookup in the same cycle still sees the old contents. No other entry changes.
- R6: When the looked-up set has at least one invalid way, victim_way is the lowest-numbered invalid way.
- R7: With two ways and a full set, victim_way is the way not most recently used. An entry becomes most recently used through a lookup hit while lk_en is high, or through an allocation. When both touch the same set in the same cycle, the allocation wins. After reset every set records way 0 as most recently used.
- R8: With one way the unit is direct mapped: one entry per set, hit_way is a single bit, and victim_way is always 0.
- R9: With as many ways as frames there is one set and no set field, the tag is the whole block number, and on a full set the victim is the way numbered one above the most recently used (wrapping to 0).
- R10: A lookup with lk_en low does not change the replacement state. With the address held and no allocation, victim_way stays the same on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup is real; a hit updates recency |
| lk_addr | input | ADDR_W | Word address being looked up |
| hit_way | output | WAYS | Per-way match vector |
| hit | output | 1 | Any way matched |
| victim_way | output | WIDX_W | Way proposed for replacement in the looked-up set |
| alloc_en | input | 1 | Write a tag this cycle |
| alloc_addr | input | ADDR_W | Address whose block is being installed |
| alloc_way | input | WIDX_W | Way that receives the tag |

## Verification
The bench builds three copies of the unit side by side, with one, two and eight ways over the default eight frames.

The one-way copy exercises direct mapping, where an address can only ever displace the single block sharing its set. The two-way copy exercises recency-based replacement in four sets. The eight-way copy collapses to a single set with a four-bit tag, so eviction order depends on round-robin replacement across all frames.

All three run the same directed phases and random traffic against a behavioural model. This compares hits, the match vector and the proposed victim on every cycle.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

    // Width of an index over n items; never less than one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Which fallback policy a full set uses.
    typedef enum logic [1:0] {
        REPL_FIXED = 2'd0,   // single way: always way 0
        REPL_LRU   = 2'd1,   // two ways: the other one
        REPL_ROUND = 2'd2    // more ways: the one after the last used
    } repl_kind_e;

    function automatic repl_kind_e repl_kind(input int unsigned ways);
        if (ways == 1) return REPL_FIXED;
        if (ways == 2) return REPL_LRU;
        return REPL_ROUND;
    endfunction

endpackage

// File: rtl/lkp_tag_way.sv
// One way: per-set tag and valid storage plus its comparator.
module lkp_tag_way #(
    parameter int SETS  = 4,
    parameter int TAG_W = 2,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic             rd_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    typedef struct packed {
        logic [SETS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0]            vld;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tag[wr_idx] = wr_tag;
            st_d.vld[wr_idx] = 1'b1;
        end
        rd_vld = st_q.vld[rd_idx];
        rd_hit = st_q.vld[rd_idx] && (st_q.tag[rd_idx] == rd_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lkp_repl.sv
// Per-set recency record and victim choice.
module lkp_repl #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int IDX_W  = 2,
    parameter int WIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WAYS-1:0]   lk_vld,
    input  logic              lk_touch,
    input  logic [WIDX_W-1:0] lk_way,
    input  logic              al_en,
    input  logic [IDX_W-1:0]  al_idx,
    input  logic [WIDX_W-1:0] al_way,
    output logic [WIDX_W-1:0] victim
);

    typedef struct packed {
        logic [SETS-1:0][WIDX_W-1:0] mru;
    } repl_t;

    repl_t st_d, st_q;

    logic [WIDX_W-1:0] cur_mru;
    logic [WIDX_W-1:0] full_pick;
    logic [WIDX_W-1:0] free_pick;
    logic              free_any;

    assign cur_mru = st_q.mru[lk_idx];

    // Policy for a full set, chosen by the number of ways.
    generate
        if (lkp_pkg::repl_kind(WAYS) == lkp_pkg::REPL_FIXED) begin : g_fixed
            assign full_pick = '0;
        end else if (lkp_pkg::repl_kind(WAYS) == lkp_pkg::REPL_LRU) begin : g_lru
            assign full_pick = ~cur_mru;
        end else begin : g_round
            assign full_pick = (cur_mru == WIDX_W'(WAYS - 1)) ? '0 : cur_mru + 1'b1;
        end
    endgenerate

    always_comb begin
        free_pick = '0;
        free_any  = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!lk_vld[w]) begin
                free_pick = WIDX_W'(w);
                free_any  = 1'b1;
            end
        end
        victim = free_any ? free_pick : full_pick;

        st_d = st_q;
        if (lk_touch) st_d.mru[lk_idx] = lk_way;
        if (al_en)    st_d.mru[al_idx] = al_way;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lkp_set_assoc_tags.sv
module lkp_set_assoc_tags #(
    parameter int FRAMES      = 8,
    parameter int WAYS        = 2,
    parameter int BLOCK_WORDS = 8,
    parameter int MEM_WORDS   = 128,
    localparam int ADDR_W = $clog2(MEM_WORDS),
    localparam int WIDX_W = lkp_pkg::idx_w(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [WAYS-1:0]   hit_way,
    output logic              hit,
    output logic [WIDX_W-1:0] victim_way,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [WIDX_W-1:0] alloc_way
);

    localparam int OFF_W = $clog2(BLOCK_WORDS);
    localparam int SETS  = FRAMES / WAYS;
    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = lkp_pkg::idx_w(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    logic [IDX_W-1:0]  lk_idx, al_idx;
    logic [TAG_W-1:0]  lk_tag, al_tag;
    logic [WAYS-1:0]   lk_set_vld;
    logic [WIDX_W-1:0] hit_idx;

    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign al_tag = alloc_addr[ADDR_W-1 -: TAG_W];

    // Set field exists only when there is more than one set.
    generate
        if (SET_W > 0) begin : g_set_field
            assign lk_idx = IDX_W'(lk_addr[OFF_W + SET_W - 1 : OFF_W]);
            assign al_idx = IDX_W'(alloc_addr[OFF_W + SET_W - 1 : OFF_W]);
        end else begin : g_one_set
            assign lk_idx = '0;
            assign al_idx = '0;
        end
    endgenerate

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            lkp_tag_way #(
                .SETS (SETS),
                .TAG_W(TAG_W),
                .IDX_W(IDX_W)
            ) i_way (
                .clk   (clk),
                .rst_n (rst_n),
                .rd_idx(lk_idx),
                .rd_tag(lk_tag),
                .rd_vld(lk_set_vld[w]),
                .rd_hit(hit_way[w]),
                .wr_en (alloc_en && (alloc_way == WIDX_W'(w))),
                .wr_idx(al_idx),
                .wr_tag(al_tag)
            );
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_way[w]) hit_idx = WIDX_W'(w);
        end
        hit = |hit_way;
    end

    lkp_repl #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .WIDX_W(WIDX_W)
    ) i_repl (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (lk_idx),
        .lk_vld  (lk_set_vld),
        .lk_touch(lk_en && hit),
        .lk_way  (hit_idx),
        .al_en   (alloc_en),
        .al_idx  (al_idx),
        .al_way  (alloc_way),
        .victim  (victim_way)
    );

endmodule

// File: rtl/lkp_set_assoc_tags_chk.sv
module lkp_set_assoc_tags_chk #(
    parameter int WAYS   = 2,
    parameter int ADDR_W = 7,
    parameter int WIDX_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_en,
    input logic [ADDR_W-1:0] lk_addr,
    input logic [WAYS-1:0]   hit_way,
    input logic [WIDX_W-1:0] victim_way,
    input logic              alloc_en,
    input logic [ADDR_W-1:0] alloc_addr,
    input logic [WIDX_W-1:0] alloc_way,
    input logic [WAYS-1:0]   lk_set_vld
);

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (hit_way == '0)); // R2

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_way & ~lk_set_vld) == '0)); // R3

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_way)); // R4

    AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_en) && (lk_addr == $past(alloc_addr)))
        |-> (hit_way == (WAYS'(1) << $past(alloc_way)))); // R5

    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_set_vld != '1) |-> !lk_set_vld[victim_way]); // R6

    AST_QUIET_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!lk_en && !alloc_en) && $stable(lk_addr))
        |-> $stable(victim_way)); // R10

endmodule

bind lkp_set_assoc_tags lkp_set_assoc_tags_chk #(
    .WAYS  (WAYS),
    .ADDR_W(ADDR_W),
    .WIDX_W(WIDX_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_en     (lk_en),
    .lk_addr   (lk_addr),
    .hit_way   (hit_way),
    .victim_way(victim_way),
    .alloc_en  (alloc_en),
    .alloc_addr(alloc_addr),
    .alloc_way (alloc_way),
    .lk_set_vld(lk_set_vld)
);

// File: tb/test_lkp_set_assoc_tags.sv
// One harness per associativity, each with its own reference model.
module lkp_bench #(
    parameter int WAYS = 2
) (
    input  logic clk,
    output logic done,
    output int   nchk,
    output int   nfail
);
    localparam int FRAMES = 8;
    localparam int BLKW   = 8;
    localparam int MEMW   = 128;
    localparam int ADDR_W = $clog2(MEMW);
    localparam int WIDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int SETS   = FRAMES / WAYS;
    localparam int OFF    = $clog2(BLKW);
    localparam int SB     = $clog2(SETS);
    localparam int TAGS   = (MEMW / BLKW) / SETS;

    logic              rst_n;
    logic              lk_en, alloc_en;
    logic [ADDR_W-1:0] lk_addr, alloc_addr;
    logic [WIDX_W-1:0] alloc_way;
    logic [WAYS-1:0]   hit_way;
    logic              hit;
    logic [WIDX_W-1:0] victim_way;

    lkp_set_assoc_tags #(
        .FRAMES(FRAMES), .WAYS(WAYS), .BLOCK_WORDS(BLKW), .MEM_WORDS(MEMW)
    ) i_lkp_set_assoc_tags (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
        .hit_way(hit_way), .hit(hit), .victim_way(victim_way),
        .alloc_en(alloc_en), .alloc_addr(alloc_addr), .alloc_way(alloc_way)
    );

    int mtag [SETS][WAYS];
    bit mvld [SETS][WAYS];
    int mmru [SETS];

    function automatic int set_of(int a);
        return (a >> OFF) % SETS;
    endfunction
    function automatic int tag_of(int a);
        return a >> (OFF + SB);
    endfunction
    function automatic int addr_of(int t, int s);
        return ((t % TAGS) << (OFF + SB)) | (s << OFF);
    endfunction
    function automatic int hit_of(int a);
        for (int w = 0; w < WAYS; w++)
            if (mvld[set_of(a)][w] && mtag[set_of(a)][w] == tag_of(a)) return w;
        return -1;
    endfunction
    function automatic int victim_of(int s);
        for (int w = 0; w < WAYS; w++) if (!mvld[s][w]) return w;
        if (WAYS == 1) return 0;
        if (WAYS == 2) return 1 - mmru[s];
        return (mmru[s] + 1) % WAYS;
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s K=%0d %s act=%0h exp=%0h", rq, WAYS, what, act, exp);
        end
    endtask

    task automatic step(bit le, int la, bit ae, int aa, int aw, string rq);
        int hw;
        int ev;
        lk_en      = le;
        lk_addr    = ADDR_W'(la);
        alloc_en   = ae;
        alloc_addr = ADDR_W'(aa);
        alloc_way  = WIDX_W'(aw);
        #1;
        hw = hit_of(la);
        ev = (hw < 0) ? 0 : (1 << hw);
        chk(int'(hit_way) == ev, rq, "hit_way", int'(hit_way), ev);
        chk(hit == (hw >= 0), rq, "hit", int'(hit), int'(hw >= 0));
        chk(int'(victim_way) == victim_of(set_of(la)), rq, "victim",
            int'(victim_way), victim_of(set_of(la)));
        chk($countones(hit_way) <= 1, "R4", "two ways hit", int'(hit_way), ev);
        if (le && hw >= 0) mmru[set_of(la)] = hw;
        if (ae) begin
            mtag[set_of(aa)][aw] = tag_of(aa);
            mvld[set_of(aa)][aw] = 1'b1;
            mmru[set_of(aa)]     = aw;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        string fr;
        done = 0; nchk = 0; nfail = 0;
        rst_n = 0; lk_en = 0; alloc_en = 0; lk_addr = '0; alloc_addr = '0; alloc_way = '0;
        for (int s = 0; s < SETS; s++) begin
            mmru[s] = 0;
            for (int w = 0; w < WAYS; w++) begin mvld[s][w] = 0; mtag[s][w] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R2: empty after reset
        for (int a = 0; a < 16; a++) step(1, a * 8, 0, 0, 0, "R2");

        // R1: offsets ignored, set/tag fields separate blocks
        step(0, 0, 1, 7'h2B, victim_of(set_of(7'h2B)), "R1");
        for (int o = 0; o < 8; o++) step(1, (7'h2B & ~7) | o, 0, 0, 0, "R1");
        step(1, 7'h2B ^ 7'h08, 0, 0, 0, "R1");
        step(1, 7'h2B ^ 7'h20, 0, 0, 0, "R1");
        step(1, 7'h2B ^ 7'h40, 0, 0, 0, "R1");

        // R6: fill set 0 one way at a time
        for (int t = 0; t < WAYS; t++) begin
            step(1, addr_of(t, 0), 0, 0, 0, "R6");
            if (hit_of(addr_of(t, 0)) < 0)
                step(0, 0, 1, addr_of(t, 0), victim_of(0), "R6");
        end

        // R7 / R8 / R9: replacement in a full set
        fr = (WAYS == 1) ? "R8" : (WAYS == FRAMES) ? "R9" : "R7";
        for (int i = 0; i < 12; i++) begin
            step(1, addr_of(i % TAGS, 0), 0, 0, 0, fr);
            if (hit_of(addr_of(WAYS + i, 0)) < 0)
                step(1, addr_of(WAYS + i, 0), 1, addr_of(WAYS + i, 0), victim_of(0), fr);
            step(1, addr_of(WAYS + i, 0), 0, 0, 0, fr);
        end

        // R5: allocation visible next cycle, not in the same one
        for (int i = 0; i < 6; i++) begin
            int a;
            a = addr_of(i + 3, i % SETS);
            if (hit_of(a) < 0) begin
                step(1, a, 1, a, victim_of(set_of(a)), "R5");
                step(1, a, 0, 0, 0, "R5");
            end
        end

        // R10: lookups without lk_en leave recency alone
        for (int i = 0; i < 8; i++) step(0, addr_of(i, i % SETS), 0, 0, 0, "R10");
        for (int i = 0; i < 4; i++) step(0, addr_of(1, 0), 0, 0, 0, "R10");

        // R3: random traffic
        for (int i = 0; i < 300; i++) begin
            int la, aa, aw;
            bit le, ae;
            la = int'($urandom % MEMW);
            le = bit'($urandom % 2);
            ae = ($urandom % 3) == 0;
            aa = int'($urandom % MEMW);
            if (hit_of(aa) >= 0)        aw = hit_of(aa);
            else if ($urandom % 4 == 0) aw = int'($urandom % WAYS);
            else                        aw = victim_of(set_of(aa));
            step(le, la, ae, aa, aw, "R3");
        end
        lk_en = 0; alloc_en = 0;
        done = 1;
    end
endmodule

module test_lkp_set_assoc_tags;
    localparam int CLK_PERIOD = 10;

    logic clk = 0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic d1, d2, d8;
    int   c1, c2, c8, f1, f2, f8;

    lkp_bench #(.WAYS(1)) i_k1 (.clk(clk), .done(d1), .nchk(c1), .nfail(f1));
    lkp_bench #(.WAYS(2)) i_k2 (.clk(clk), .done(d2), .nchk(c2), .nfail(f2));
    lkp_bench #(.WAYS(8)) i_k8 (.clk(clk), .done(d8), .nchk(c8), .nfail(f8));

    initial begin
        int cyc;
        int tot;
        int bad;
        cyc = 0;
        while (!(d1 === 1'b1 && d2 === 1'b1 && d8 === 1'b1) && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        #1;
        tot = c1 + c2 + c8;
        bad = f1 + f2 + f8;
        if (cyc >= 20000) begin
            tot++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
        end
        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    end
endmodule